// File: doc/BRIEF.md
# Adaptive Page Relocation Threshold Controller

This block sits in the memory controller of one node in a hybrid shared-memory machine. Each node holds a set of local page frames that can cache remotely homed pages. The block chooses how each newly touched remote page is mapped. If a frame is free and the node is not thrashing, the page gets the lowest-numbered free frame. Otherwise the page stays in remote-access mode. The block also keeps a count of free frames and compares it with a low watermark and a refill target.

When the pool falls below the low watermark, the block runs a reclaim sweep. A sweep can start only after a minimum number of ticks has passed since the previous sweep. The sweep visits every frame in ascending order and clears each reference bit. A cached frame whose bit is still clear when the sweep reaches it is cold. The sweep asks the flush engine to evict cold frames, one at a time, until the pool reaches the target.

The result of each sweep adjusts two outputs. One is the refetch threshold that the counter logic uses to decide page promotion. The other is the sweep interval. A sweep that cannot refill the pool raises the threshold, lengthens the interval and marks the node as thrashing. A successful sweep that finds more cold frames than the previous sweep lowers the threshold again. This damping stops hot pages from repeatedly displacing each other in the cache.

Top module: `reloc_thresh_ctrl`

## Requirements
- R1: While the free count is non-zero and the thrashing flag is clear, `alloc_cached` is 1 and `alloc_frame` is the lowest-numbered free frame. An `alloc_req` in that state claims that frame and sets its reference bit. When no frame is free, `alloc_cached` is 0.
- R2: A sweep starts only when two conditions hold. The free count must be below the low watermark, which is floor(FRAMES*LOW_PCT/100). At least `sweep_interval` ticks must have passed since the last sweep ended, or since reset if no sweep has run.
- R3: A sweep visits frames 0 to FRAMES-1 and clears every reference bit. A cached frame whose bit is 0 counts as cold. Cold frames are evicted in ascending order, and only while the free count is below the target, which is floor(FRAMES*TGT_PCT/100).
- R4: `evict_valid` and `evict_frame` stay fixed until `evict_ready` is seen. The free count rises only on that handshake.
- R5: When a sweep ends below the target, the thrashing flag is set and `alloc_cached` becomes 0 even if frames are free. The threshold rises by THR_STEP, saturating at THR_MAX. The interval rises by IVL_STEP, saturating at IVL_MAX.
- R6: When a sweep reaches the target and finds more cold frames than the previous sweep, the threshold falls by THR_STEP, but never below THR_INIT. If this returns it to THR_INIT, the interval returns to IVL_BASE.
- R7: When a sweep reaches the target without finding more cold frames than the previous one, the thrashing flag clears and the threshold and interval are unchanged.
- R8: `reloc_disabled` is 1 exactly while the threshold equals THR_MAX.
- R9: After reset, all FRAMES frames are free, the threshold is THR_INIT, the interval is IVL_BASE, and `thrashing`, `reloc_disabled` and `evict_valid` are 0.
- R10: `free_evt` returns a cached frame to the pool. On a frame that is already free, it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | New remote page touched, needs a mapping decision |
| alloc_cached | output | 1 | 1: map the page into a local frame, 0: keep it remote |
| alloc_frame | output | $clog2(FRAMES) | Frame granted when cached |
| free_evt | input | 1 | A cached page was unmapped elsewhere |
| free_frame | input | $clog2(FRAMES) | Frame released by `free_evt` |
| ref_set | input | 1 | Reference bit set for a frame |
| ref_frame | input | $clog2(FRAMES) | Frame whose reference bit is set |
| tick | input | 1 | Time base for the sweep interval |
| evict_valid | output | 1 | Eviction request to the flush engine |
| evict_frame | output | $clog2(FRAMES) | Frame to flush |
| evict_ready | input | 1 | Flush engine has completed the request |
| free_frames | output | $clog2(FRAMES+1) | Current free-pool size |
| threshold | output | $clog2(THR_MAX+1) | Refetch threshold published to the counter logic |
| sweep_interval | output | $clog2(IVL_MAX+1) | Minimum number of ticks between sweeps |
| thrashing | output | 1 | Last sweep failed to refill the pool |
| reloc_disabled | output | 1 | Threshold is at its ceiling, so promotion is off |

## Verification
The bench builds the block with 16 frames, a 25 % low watermark (4 frames) and a 50 % target (8 frames). The threshold starts at 32, steps by 8 and saturates at 56. The interval starts at 4 ticks and steps by 4.

With only 16 frames, the whole pool can be filled one frame at a time and every frame's grant can be checked. A full sweep fits in a few dozen cycles. Three failing sweeps reach the ceiling, and a fourth shows that the threshold saturates. The pool is small enough that a sweep's cold count can be forced above, and then below, the previous sweep's count, so both the lowering path and the no-change path are exercised.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  typedef enum logic [1:0] {SW_IDLE, SW_SCAN, SW_WAIT, SW_DONE} sweep_state_t;

  function automatic int unsigned watermark(int unsigned frames, int unsigned pct);
    return (frames * pct) / 100;
  endfunction

  function automatic int unsigned step_up_sat(int unsigned v, int unsigned step,
                                              int unsigned ceil_v);
    return (v + step > ceil_v) ? ceil_v : v + step;
  endfunction

  function automatic int unsigned step_down_floor(int unsigned v, int unsigned step,
                                                  int unsigned floor_v);
    return (v < floor_v + step) ? floor_v : v - step;
  endfunction

endpackage

// File: rtl/reloc_frame_table.sv
module reloc_frame_table #(
  parameter int FRAMES = 64,
  parameter int FW     = $clog2(FRAMES),
  parameter int CW     = $clog2(FRAMES+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_take,
  input  logic              free_evt,
  input  logic [FW-1:0]     free_frame,
  input  logic              ref_set,
  input  logic [FW-1:0]     ref_frame,
  input  logic              clr_en,
  input  logic [FW-1:0]     clr_idx,
  input  logic              rel_en,
  input  logic [FW-1:0]     rel_idx,
  output logic [FRAMES-1:0] used,
  output logic [FRAMES-1:0] refb,
  output logic [FW-1:0]     pick,
  output logic              has_free,
  output logic [CW-1:0]     free_cnt
);

  always_comb begin
    pick     = '0;
    has_free = 1'b0;
    for (int i = FRAMES - 1; i >= 0; i--) begin
      if (!used[i]) begin
        pick     = FW'(i);
        has_free = 1'b1;
      end
    end
  end

  assign free_cnt = CW'($countones(~used));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      refb <= '0;
    end else begin
      if (clr_en)   refb[clr_idx]    <= 1'b0;
      if (ref_set)  refb[ref_frame]  <= 1'b1;
      if (free_evt) used[free_frame] <= 1'b0;
      if (rel_en)   used[rel_idx]    <= 1'b0;
      if (alloc_take) begin
        used[pick] <= 1'b1;
        refb[pick] <= 1'b1;
      end
    end
  end

  // R4
  free_only_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_take && !free_evt && !rel_en) |=> $stable(free_cnt));

endmodule

// File: rtl/reloc_sweep.sv
module reloc_sweep
  import reloc_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int LOW    = 3,
  parameter int TGT    = 4,
  parameter int FW     = $clog2(FRAMES),
  parameter int CW     = $clog2(FRAMES+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [FRAMES-1:0] used,
  input  logic [FRAMES-1:0] refb,
  input  logic [CW-1:0]     free_cnt,
  input  logic              evict_ready,
  output logic              evict_valid,
  output logic [FW-1:0]     evict_frame,
  output logic              clr_en,
  output logic [FW-1:0]     clr_idx,
  output logic              rel_en,
  output logic [FW-1:0]     rel_idx,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     cold_cnt
);

  localparam logic [CW-1:0] LOW_W  = CW'(LOW);
  localparam logic [CW-1:0] TGT_W  = CW'(TGT);
  localparam logic [FW-1:0] LAST_W = FW'(FRAMES - 1);

  sweep_state_t st;
  logic [FW-1:0] idx;
  logic          cur_cold, need_more, at_last;

  assign cur_cold    = used[idx] && !refb[idx];
  assign need_more   = free_cnt < TGT_W;
  assign at_last     = idx == LAST_W;
  assign clr_en      = st == SW_SCAN;
  assign clr_idx     = idx;
  assign evict_valid = st == SW_WAIT;
  assign evict_frame = idx;
  assign rel_en      = (st == SW_WAIT) && evict_ready;
  assign rel_idx     = idx;
  assign busy        = st != SW_IDLE;
  assign done        = st == SW_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SW_IDLE;
      idx      <= '0;
      cold_cnt <= '0;
    end else begin
      case (st)
        SW_IDLE: if (go) begin
          st       <= SW_SCAN;
          idx      <= '0;
          cold_cnt <= '0;
        end
        SW_SCAN: begin
          if (cur_cold) cold_cnt <= cold_cnt + 1'b1;
          if (cur_cold && need_more) st <= SW_WAIT;
          else if (at_last)          st <= SW_DONE;
          else                       idx <= idx + 1'b1;
        end
        SW_WAIT: if (evict_ready) begin
          if (at_last) st <= SW_DONE;
          else begin
            st  <= SW_SCAN;
            idx <= idx + 1'b1;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  // R4
  evict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_frame)));

  // R3
  evict_below_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evict_valid) |-> ($past(free_cnt) < TGT_W));

  // R2
  sweep_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(free_cnt) < LOW_W));

endmodule

// File: rtl/reloc_backoff.sv
module reloc_backoff
  import reloc_pkg::*;
#(
  parameter int THR_INIT = 32,
  parameter int THR_STEP = 8,
  parameter int THR_MAX  = 96,
  parameter int IVL_BASE = 16,
  parameter int IVL_STEP = 16,
  parameter int IVL_MAX  = 128,
  parameter int LOW      = 3,
  parameter int TGT      = 4,
  parameter int CW       = 7,
  parameter int TW       = $clog2(THR_MAX+1),
  parameter int IW       = $clog2(IVL_MAX+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sweep_done,
  input  logic          sweep_busy,
  input  logic [CW-1:0] cold_cnt,
  input  logic [CW-1:0] free_cnt,
  output logic [TW-1:0] threshold,
  output logic [IW-1:0] interval,
  output logic          thrashing,
  output logic          reloc_disabled,
  output logic          sweep_go
);

  localparam logic [CW-1:0] LOW_W  = CW'(LOW);
  localparam logic [CW-1:0] TGT_W  = CW'(TGT);
  localparam logic [TW-1:0] INIT_W = TW'(THR_INIT);
  localparam logic [TW-1:0] MAX_W  = TW'(THR_MAX);
  localparam logic [IW-1:0] BASE_W = IW'(IVL_BASE);

  logic [IW-1:0] timer;
  logic [CW-1:0] prev_cold;
  logic [TW-1:0] thr_up, thr_dn;
  logic [IW-1:0] ivl_up;

  assign thr_up = TW'(step_up_sat(32'(threshold), THR_STEP, THR_MAX));
  assign thr_dn = TW'(step_down_floor(32'(threshold), THR_STEP, THR_INIT));
  assign ivl_up = IW'(step_up_sat(32'(interval), IVL_STEP, IVL_MAX));

  assign reloc_disabled = threshold == MAX_W;
  assign sweep_go       = !sweep_busy && (timer >= interval) && (free_cnt < LOW_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      threshold <= INIT_W;
      interval  <= BASE_W;
      thrashing <= 1'b0;
      timer     <= '0;
      prev_cold <= '0;
    end else begin
      if (sweep_done)               timer <= '0;
      else if (tick && timer != '1) timer <= timer + 1'b1;
      if (sweep_done) begin
        prev_cold <= cold_cnt;
        if (free_cnt < TGT_W) begin
          thrashing <= 1'b1;
          threshold <= thr_up;
          interval  <= ivl_up;
        end else begin
          thrashing <= 1'b0;
          if (cold_cnt > prev_cold) begin
            threshold <= thr_dn;
            if (thr_dn == INIT_W) interval <= BASE_W;
          end
        end
      end else if (thrashing && free_cnt >= TGT_W) begin
        thrashing <= 1'b0;
      end
    end
  end

  // R5
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold >= INIT_W) && (threshold <= MAX_W));

  // R6
  thr_moves_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(threshold) |-> $past(sweep_done));

  // R6
  ivl_base_at_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((threshold == INIT_W) && !$stable(threshold)) |-> (interval == BASE_W));

endmodule

// File: rtl/reloc_thresh_ctrl.sv
module reloc_thresh_ctrl
  import reloc_pkg::*;
#(
  parameter int FRAMES   = 64,
  parameter int LOW_PCT  = 5,
  parameter int TGT_PCT  = 7,
  parameter int THR_INIT = 32,
  parameter int THR_STEP = 8,
  parameter int THR_MAX  = 96,
  parameter int IVL_BASE = 16,
  parameter int IVL_STEP = 16,
  parameter int IVL_MAX  = 128,
  localparam int FW      = $clog2(FRAMES),
  localparam int CW      = $clog2(FRAMES+1),
  localparam int TW      = $clog2(THR_MAX+1),
  localparam int IW      = $clog2(IVL_MAX+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          alloc_cached,
  output logic [FW-1:0] alloc_frame,
  input  logic          free_evt,
  input  logic [FW-1:0] free_frame,
  input  logic          ref_set,
  input  logic [FW-1:0] ref_frame,
  input  logic          tick,
  output logic          evict_valid,
  output logic [FW-1:0] evict_frame,
  input  logic          evict_ready,
  output logic [CW-1:0] free_frames,
  output logic [TW-1:0] threshold,
  output logic [IW-1:0] sweep_interval,
  output logic          thrashing,
  output logic          reloc_disabled
);

  localparam int LOW = int'(watermark(FRAMES, LOW_PCT));
  localparam int TGT = int'(watermark(FRAMES, TGT_PCT));

  logic [FRAMES-1:0] used, refb;
  logic [FW-1:0]     pick, clr_idx, rel_idx;
  logic              has_free, alloc_take, clr_en, rel_en;
  logic              sweep_go, sweep_busy, sweep_done;
  logic [CW-1:0]     cold_cnt;

  assign alloc_cached = has_free && !thrashing;
  assign alloc_frame  = pick;
  assign alloc_take   = alloc_req && alloc_cached;

  reloc_frame_table #(.FRAMES(FRAMES), .FW(FW), .CW(CW)) i_table (
    .clk(clk), .rst_n(rst_n), .alloc_take(alloc_take),
    .free_evt(free_evt), .free_frame(free_frame),
    .ref_set(ref_set), .ref_frame(ref_frame),
    .clr_en(clr_en), .clr_idx(clr_idx), .rel_en(rel_en), .rel_idx(rel_idx),
    .used(used), .refb(refb), .pick(pick), .has_free(has_free),
    .free_cnt(free_frames)
  );

  reloc_sweep #(.FRAMES(FRAMES), .LOW(LOW), .TGT(TGT), .FW(FW), .CW(CW)) i_sweep (
    .clk(clk), .rst_n(rst_n), .go(sweep_go), .used(used), .refb(refb),
    .free_cnt(free_frames), .evict_ready(evict_ready),
    .evict_valid(evict_valid), .evict_frame(evict_frame),
    .clr_en(clr_en), .clr_idx(clr_idx), .rel_en(rel_en), .rel_idx(rel_idx),
    .busy(sweep_busy), .done(sweep_done), .cold_cnt(cold_cnt)
  );

  reloc_backoff #(
    .THR_INIT(THR_INIT), .THR_STEP(THR_STEP), .THR_MAX(THR_MAX),
    .IVL_BASE(IVL_BASE), .IVL_STEP(IVL_STEP), .IVL_MAX(IVL_MAX),
    .LOW(LOW), .TGT(TGT), .CW(CW), .TW(TW), .IW(IW)
  ) i_backoff (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sweep_done(sweep_done), .sweep_busy(sweep_busy),
    .cold_cnt(cold_cnt), .free_cnt(free_frames),
    .threshold(threshold), .interval(sweep_interval),
    .thrashing(thrashing), .reloc_disabled(reloc_disabled), .sweep_go(sweep_go)
  );

  // R1
  alloc_claims_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_cached && !free_evt && !rel_en) |=>
      (free_frames == $past(free_frames) - 1'b1));

endmodule

// File: tb/test_reloc_thresh_ctrl.sv
`timescale 1ns/1ps
module test_reloc_thresh_ctrl;

  localparam int FRAMES = 16;
  localparam int LOWW   = (FRAMES * 25) / 100;
  localparam int TGTW   = (FRAMES * 50) / 100;
  localparam int T_INIT = 32;
  localparam int T_STEP = 8;
  localparam int T_MAX  = 56;
  localparam int I_BASE = 4;
  localparam int I_STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, free_evt = 1'b0, ref_set = 1'b0, tick = 1'b0, evict_ready = 1'b0;
  logic [3:0] free_frame = '0, ref_frame = '0;
  logic alloc_cached, evict_valid, thrashing, reloc_disabled;
  logic [3:0] alloc_frame, evict_frame;
  logic [4:0] free_frames;
  logic [5:0] threshold;
  logic [6:0] sweep_interval;

  int checks = 0;
  int errors = 0;
  int exp_thr = T_INIT;
  int exp_ivl = I_BASE;

  always #10 clk = ~clk;

  reloc_thresh_ctrl #(
    .FRAMES(FRAMES), .LOW_PCT(25), .TGT_PCT(50), .THR_INIT(T_INIT), .THR_STEP(T_STEP),
    .THR_MAX(T_MAX), .IVL_BASE(I_BASE), .IVL_STEP(I_STEP), .IVL_MAX(64)
  ) i_reloc_thresh_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_cached(alloc_cached),
    .alloc_frame(alloc_frame), .free_evt(free_evt), .free_frame(free_frame),
    .ref_set(ref_set), .ref_frame(ref_frame), .tick(tick),
    .evict_valid(evict_valid), .evict_frame(evict_frame), .evict_ready(evict_ready),
    .free_frames(free_frames), .threshold(threshold), .sweep_interval(sweep_interval),
    .thrashing(thrashing), .reloc_disabled(reloc_disabled)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_alloc(int exp_frame);
    @(negedge clk);
    chk("R1 cached grant", int'(alloc_cached), 1);
    chk("R1 lowest free frame", int'(alloc_frame), exp_frame);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic give_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic touch_all();
    for (int i = 0; i < FRAMES; i++) begin
      @(negedge clk); ref_set = 1'b1; ref_frame = 4'(i);
    end
    @(negedge clk); ref_set = 1'b0;
  endtask

  task automatic expect_evictions(int first, int n);
    int w;
    int fb;
    int extra;
    for (int k = 0; k < n; k++) begin
      w = 0;
      while (!evict_valid && w < 80) begin @(negedge clk); w++; end
      chk("R3 eviction issued", int'(evict_valid), 1);
      chk("R3 eviction order", int'(evict_frame), first + k);
      fb = int'(free_frames);
      if (k == 0) begin
        repeat (3) @(negedge clk);
        chk("R4 request held", int'(evict_valid), 1);
        chk("R4 frame held", int'(evict_frame), first);
        chk("R4 no count before ready", int'(free_frames), fb);
      end
      evict_ready = 1'b1;
      @(negedge clk);
      evict_ready = 1'b0;
      chk("R4 count after handshake", int'(free_frames), fb + 1);
    end
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (evict_valid) extra++;
    end
    chk("R3 no eviction past target", extra, 0);
  endtask

  task automatic check_backoff(string req, int thr, int ivl, int thr_flag);
    chk({req, " threshold"}, int'(threshold), thr);
    chk({req, " interval"}, int'(sweep_interval), ivl);
    chk({req, " thrashing"}, int'(thrashing), thr_flag);
    chk("R8 disabled flag", int'(reloc_disabled), (thr == T_MAX) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 free frames", int'(free_frames), FRAMES);
    chk("R9 evict idle", int'(evict_valid), 0);
    check_backoff("R9", T_INIT, I_BASE, 0);

    // R1: fill the pool in order
    for (int i = 0; i < FRAMES; i++) do_alloc(i);
    @(negedge clk);
    chk("R1 remote when empty", int'(alloc_cached), 0);
    chk("R1 pool empty", int'(free_frames), 0);

    // R5: all frames referenced, sweep fails
    give_ticks(I_BASE);
    repeat (40) @(negedge clk);
    exp_thr = T_INIT + T_STEP; exp_ivl = I_BASE + I_STEP;
    check_backoff("R5 first failure", exp_thr, exp_ivl, 1);

    // R10 / R5: freed frame under thrashing stays remote
    @(negedge clk); free_evt = 1'b1; free_frame = 4'd0;
    @(negedge clk); free_evt = 1'b0;
    chk("R10 free returns frame", int'(free_frames), 1);
    chk("R5 remote while thrashing", int'(alloc_cached), 0);

    // R2: interval gating
    give_ticks(exp_ivl - 1);
    seen = 0;
    repeat (30) begin @(negedge clk); if (evict_valid) seen++; end
    chk("R2 no sweep before interval", seen, 0);
    give_ticks(1);
    expect_evictions(1, TGTW - 1);
    exp_thr = T_INIT; exp_ivl = I_BASE;
    check_backoff("R6 relax to init", exp_thr, exp_ivl, 0);
    chk("R3 refilled to target", int'(free_frames), TGTW);

    // R5 / R8: repeated failures up to saturation
    for (int i = 0; i < TGTW; i++) do_alloc(i);
    for (int s = 0; s < 4; s++) begin
      touch_all();
      give_ticks(exp_ivl);
      repeat (40) @(negedge clk);
      exp_thr = (exp_thr + T_STEP > T_MAX) ? T_MAX : exp_thr + T_STEP;
      exp_ivl = exp_ivl + I_STEP;
      check_backoff("R5 backoff", exp_thr, exp_ivl, 1);
    end

    // R6: all 16 cold, more than previous 0
    give_ticks(exp_ivl);
    expect_evictions(0, TGTW);
    exp_thr = exp_thr - T_STEP;
    check_backoff("R6 lower", exp_thr, exp_ivl, 0);

    // R7: 8 cold, not more than previous 16
    for (int i = 0; i < TGTW; i++) do_alloc(i);
    chk("R1 pool empty again", int'(free_frames), 0);
    give_ticks(exp_ivl);
    expect_evictions(TGTW, FRAMES - TGTW);
    check_backoff("R7 unchanged", exp_thr, exp_ivl, 0);
    chk("R7 refilled", int'(free_frames), TGTW);

    // R10: free on a free frame is ignored, on a used frame counts
    @(negedge clk); free_evt = 1'b1; free_frame = 4'd8;
    @(negedge clk); free_evt = 1'b0;
    chk("R10 ignore free frame", int'(free_frames), TGTW);
    @(negedge clk); free_evt = 1'b1; free_frame = 4'd0;
    @(negedge clk); free_evt = 1'b0;
    chk("R10 release used frame", int'(free_frames), TGTW + 1);
    chk("R1 lowest free after release", int'(alloc_frame), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule